// File: doc/BRIEF.md
# Ladder Bit-Logic Execution Unit

This block runs a stream of ladder bit-logic instructions. It takes one instruction per clock against a 256-bit internal bit memory. By convention the low addresses hold the input image, the middle range holds the output image and the upper range holds marker bits. The hardware treats all 256 bits the same way. The block keeps a result bit (`rlo_o`) and a status bit (`br_o`). Each instruction carries an opcode, a primary address `addr_a_i` and a secondary address `addr_b_i`. For edge operations, the secondary address names the memory bit that holds the previous state.

A rung begins with an instruction presented together with `net_start_i`. The next contact-class instruction then loads its result into RLO. Each later contact-class instruction ANDs its result into RLO. Between scans, the host writes input bits through a one-bit port and reads any bit back combinationally. Each instruction finishes in one clock. Its memory write, RLO and BR are visible after that edge.

The flip-flop instructions take their set input from RLO and their reset input from the bit at `addr_b_i`. The variant decides which input wins when both are active.

Top module: `ladder_bit_unit`

## Requirements
- R1: After reset, `rlo_o` and `br_o` are 0 and every memory bit reads 0.
- R2: Opcode 1 (contact, normally open) yields the bit at `addr_a_i`. Opcode 2 (contact, normally closed) yields its complement. The first contact-class instruction at or after `net_start_i` loads that result into RLO, and each later one ANDs it into RLO.
- R3: Opcode 3 (coil) writes RLO into the bit at `addr_a_i` and leaves RLO unchanged.
- R4: Opcode 4 (midline store) writes RLO into the bit at `addr_a_i`. RLO passes on unchanged, so later contacts in the same rung AND into it.
- R5: Opcode 5 replaces RLO with its complement.
- R6: Opcode 6 copies RLO into the BR bit, seen on `br_o`.
- R7: Opcode 7 (set) writes 1 and opcode 8 (reset) writes 0 to `addr_a_i`, but only when RLO is 1. When RLO is 0, the bit is unchanged.
- R8: Opcode 9 (reset-dominant flip-flop) takes set = RLO and reset = bit at `addr_b_i`. Reset active clears `addr_a_i`; otherwise set active sets it; otherwise the bit holds. RLO then takes the bit's new value.
- R9: Opcode 10 (set-dominant flip-flop) uses the same inputs. Set active sets `addr_a_i`; otherwise reset active clears it; otherwise the bit holds. RLO then takes the new value.
- R10: Opcode 11 (rising RLO edge) makes RLO 1 only if RLO is 1 and the bit at `addr_b_i` is 0. Opcode 12 (falling RLO edge) makes RLO 1 only if RLO is 0 and that bit is 1. In every other case RLO becomes 0. Both write the incoming RLO into `addr_b_i`.
- R11: Opcode 13 (address rise) yields 1 when the bit at `addr_a_i` is 1 and the bit at `addr_b_i` is 0. Opcode 14 (address fall) yields 1 for the reverse. The result acts as a contact result (load or AND per R2), and the bit at `addr_a_i` is then copied into `addr_b_i`.
- R12: A host write (`host_we_i`) stores `host_wdata_i` at `host_addr_i` only when `instr_valid_i` is low. With `instr_valid_i` high it is ignored. `host_rdata_o` shows the bit at `host_addr_i` combinationally.
- R13: Opcode 0 and opcode 15, and any cycle with `instr_valid_i` low, change neither RLO, BR nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction present this cycle |
| net_start_i | input | 1 | Instruction begins a new rung |
| opcode_i | input | 4 | Instruction opcode |
| addr_a_i | input | 8 | Primary bit address |
| addr_b_i | input | 8 | Secondary bit address (edge memory / reset input) |
| host_we_i | input | 1 | Host bit write enable |
| host_addr_i | input | 8 | Host bit address |
| host_wdata_i | input | 1 | Host write data |
| host_rdata_o | output | 1 | Bit at host address |
| rlo_o | output | 1 | Current result of logic operation |
| br_o | output | 1 | Status BR bit |

## Verification
The bench checks the rung-start load. A design that ANDs the first contact into the stale RLO from the previous rung would leave RLO stuck at 0. It drives both flip-flop variants with set and reset active together and expects opposite results. Swapped priority shows up as a wrong bit and a wrong RLO. It repeats edge instructions across two scans, so an edge memory that never updates gives a pulse that lasts too long. It also runs set and reset coils with RLO at 0 and presents a host write together with an instruction, since a missing enable would corrupt a stored bit.

// File: rtl/ladder_pkg.sv
package ladder_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'd0,
    OP_NO    = 4'd1,
    OP_NC    = 4'd2,
    OP_COIL  = 4'd3,
    OP_MID   = 4'd4,
    OP_INV   = 4'd5,
    OP_SAVE  = 4'd6,
    OP_SET   = 4'd7,
    OP_RST   = 4'd8,
    OP_SR    = 4'd9,
    OP_RS    = 4'd10,
    OP_PEDGE = 4'd11,
    OP_NEDGE = 4'd12,
    OP_APOS  = 4'd13,
    OP_ANEG  = 4'd14,
    OP_RSVD  = 4'd15
  } op_e;
endpackage

// File: rtl/ladder_bit_mem.sv
module ladder_bit_mem #(
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic              wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  input  logic [ADDR_W-1:0] raddr_b_i,
  input  logic [ADDR_W-1:0] raddr_h_i,
  output logic              rdata_a_o,
  output logic              rdata_b_o,
  output logic              rdata_h_o,
  output logic [DEPTH-1:0]  bits_o
);
  logic [DEPTH-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mem_q <= '0;
    else if (we_i)  mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
  assign rdata_h_o = mem_q[raddr_h_i];
  assign bits_o    = mem_q;
endmodule

// File: rtl/ladder_latch_resolve.sv
module ladder_latch_resolve #(
  parameter bit SET_WINS = 1'b0
) (
  input  logic set_i,
  input  logic rst_i,
  input  logic old_i,
  output logic new_o
);
  generate
    if (SET_WINS) begin : g_set_dom
      assign new_o = set_i ? 1'b1 : (rst_i ? 1'b0 : old_i);
    end else begin : g_rst_dom
      assign new_o = rst_i ? 1'b0 : (set_i ? 1'b1 : old_i);
    end
  endgenerate
endmodule

// File: rtl/ladder_rlo_eval.sv
module ladder_rlo_eval
  import ladder_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic            rlo_i,
  input  logic            first_i,
  input  logic            bit_a_i,
  input  logic            bit_b_i,
  output logic            rlo_o,
  output logic            br_we_o,
  output logic            we_o,
  output logic            wsel_b_o,
  output logic            wdata_o,
  output logic            contact_o
);
  op_e  op;
  logic sr_new, rs_new;
  logic res;

  assign op = op_e'(op_i);

  ladder_latch_resolve #(.SET_WINS(1'b0)) u_sr (
    .set_i(rlo_i), .rst_i(bit_b_i), .old_i(bit_a_i), .new_o(sr_new)
  );
  ladder_latch_resolve #(.SET_WINS(1'b1)) u_rs (
    .set_i(rlo_i), .rst_i(bit_b_i), .old_i(bit_a_i), .new_o(rs_new)
  );

  always_comb begin
    rlo_o     = rlo_i;
    br_we_o   = 1'b0;
    we_o      = 1'b0;
    wsel_b_o  = 1'b0;
    wdata_o   = rlo_i;
    contact_o = 1'b0;
    res       = 1'b0;
    unique case (op)
      OP_NO:    begin contact_o = 1'b1; res = bit_a_i;  end
      OP_NC:    begin contact_o = 1'b1; res = ~bit_a_i; end
      OP_COIL,
      OP_MID:   we_o = 1'b1;
      OP_INV:   rlo_o = ~rlo_i;
      OP_SAVE:  br_we_o = 1'b1;
      OP_SET:   begin we_o = rlo_i; wdata_o = 1'b1; end
      OP_RST:   begin we_o = rlo_i; wdata_o = 1'b0; end
      OP_SR:    begin we_o = 1'b1; wdata_o = sr_new; rlo_o = sr_new; end
      OP_RS:    begin we_o = 1'b1; wdata_o = rs_new; rlo_o = rs_new; end
      OP_PEDGE: begin we_o = 1'b1; wsel_b_o = 1'b1; rlo_o = rlo_i & ~bit_b_i; end
      OP_NEDGE: begin we_o = 1'b1; wsel_b_o = 1'b1; rlo_o = ~rlo_i & bit_b_i; end
      OP_APOS:  begin
        contact_o = 1'b1; res = bit_a_i & ~bit_b_i;
        we_o = 1'b1; wsel_b_o = 1'b1; wdata_o = bit_a_i;
      end
      OP_ANEG:  begin
        contact_o = 1'b1; res = ~bit_a_i & bit_b_i;
        we_o = 1'b1; wsel_b_o = 1'b1; wdata_o = bit_a_i;
      end
      default: ;
    endcase
    // first contact of a rung loads, later ones are in series
    if (contact_o) rlo_o = first_i ? res : (rlo_i & res);
  end
endmodule

// File: rtl/ladder_bit_unit.sv
module ladder_bit_unit
  import ladder_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic              net_start_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_wdata_i,
  output logic              host_rdata_o,
  output logic              rlo_o,
  output logic              br_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              rlo_q, br_q, first_q, first_eff;
  logic              bit_a, bit_b;
  logic              ev_rlo, ev_br_we, ev_we, ev_wsel_b, ev_wdata, ev_contact;
  logic              mem_we, mem_wdata;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DEPTH-1:0]  mem_bits;

  assign first_eff = net_start_i | first_q;

  ladder_rlo_eval u_eval (
    .op_i      (opcode_i),
    .rlo_i     (rlo_q),
    .first_i   (first_eff),
    .bit_a_i   (bit_a),
    .bit_b_i   (bit_b),
    .rlo_o     (ev_rlo),
    .br_we_o   (ev_br_we),
    .we_o      (ev_we),
    .wsel_b_o  (ev_wsel_b),
    .wdata_o   (ev_wdata),
    .contact_o (ev_contact)
  );

  // host access only in idle instruction slots
  always_comb begin
    if (instr_valid_i) begin
      mem_we    = ev_we;
      mem_waddr = ev_wsel_b ? addr_b_i : addr_a_i;
      mem_wdata = ev_wdata;
    end else begin
      mem_we    = host_we_i;
      mem_waddr = host_addr_i;
      mem_wdata = host_wdata_i;
    end
  end

  ladder_bit_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (mem_we),
    .waddr_i   (mem_waddr),
    .wdata_i   (mem_wdata),
    .raddr_a_i (addr_a_i),
    .raddr_b_i (addr_b_i),
    .raddr_h_i (host_addr_i),
    .rdata_a_o (bit_a),
    .rdata_b_o (bit_b),
    .rdata_h_o (host_rdata_o),
    .bits_o    (mem_bits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rlo_q   <= 1'b0;
      br_q    <= 1'b0;
      first_q <= 1'b1;
    end else if (instr_valid_i) begin
      rlo_q   <= ev_rlo;
      if (ev_br_we) br_q <= rlo_q;
      first_q <= ev_contact ? 1'b0 : first_eff;
    end
  end

  assign rlo_o = rlo_q;
  assign br_o  = br_q;

  a_r6_save_br: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && opcode_i == OP_SAVE |=> br_o == $past(rlo_q));

  a_r7_set_when_rlo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && opcode_i == OP_SET && rlo_q |=> mem_bits[$past(addr_a_i)]);

  a_r7_hold_when_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && (opcode_i == OP_SET || opcode_i == OP_RST) && !rlo_q
    |=> mem_bits[$past(addr_a_i)] == $past(bit_a));

  a_r5_invert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && opcode_i == OP_INV |=> rlo_q != $past(rlo_q));

  a_r10_edge_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && (opcode_i == OP_PEDGE || opcode_i == OP_NEDGE)
    |=> mem_bits[$past(addr_b_i)] == $past(rlo_q));

  a_r11_copy_prev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && (opcode_i == OP_APOS || opcode_i == OP_ANEG)
    |=> mem_bits[$past(addr_b_i)] == $past(bit_a));

  a_r13_nop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && (opcode_i == OP_NOP || opcode_i == OP_RSVD)
    |=> $stable(rlo_q) && $stable(br_q) && $stable(mem_bits));
endmodule

// File: tb/ladder_bit_unit_tb_top.sv
`timescale 1ns/1ps
module ladder_bit_unit_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       instr_valid_i = 1'b0;
  logic       net_start_i = 1'b0;
  logic [3:0] opcode_i = '0;
  logic [7:0] addr_a_i = '0;
  logic [7:0] addr_b_i = '0;
  logic       host_we_i = 1'b0;
  logic [7:0] host_addr_i = '0;
  logic       host_wdata_i = 1'b0;
  logic       host_rdata_o, rlo_o, br_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [3:0] NOP = 0, NO = 1, NC = 2, COIL = 3, MID = 4, INV = 5,
    SAVE = 6, SET = 7, RST = 8, SR = 9, RS = 10, PE = 11, NE = 12, AP = 13,
    AN = 14, RSVD = 15;

  always #4 clk_i = ~clk_i;

  ladder_bit_unit dut_i (
    .clk_i, .rst_ni, .instr_valid_i, .net_start_i, .opcode_i, .addr_a_i,
    .addr_b_i, .host_we_i, .host_addr_i, .host_wdata_i, .host_rdata_o,
    .rlo_o, .br_o
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic exec(input logic [3:0] op, input logic [7:0] a,
                      input logic [7:0] b, input logic st);
    instr_valid_i = 1'b1; opcode_i = op; addr_a_i = a; addr_b_i = b;
    net_start_i = st;
    @(negedge clk_i);
    instr_valid_i = 1'b0; net_start_i = 1'b0;
  endtask

  task automatic hwr(input logic [7:0] a, input logic v);
    host_we_i = 1'b1; host_addr_i = a; host_wdata_i = v;
    @(negedge clk_i);
    host_we_i = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic exp);
    host_addr_i = a;
    #1;
    chk(tag, host_rdata_o, exp);
  endtask

  task automatic t_reset;
    chk("R1 rlo", rlo_o, 1'b0);
    chk("R1 br", br_o, 1'b0);
    rd_chk("R1 mem0", 8'd0, 1'b0);
    rd_chk("R1 mem64", 8'd64, 1'b0);
    rd_chk("R1 mem255", 8'd255, 1'b0);
  endtask

  task automatic t_contacts;
    hwr(8'd0, 1'b1); hwr(8'd1, 1'b0);
    exec(NO, 8'd0, 8'd0, 1'b1); exec(NC, 8'd1, 8'd0, 1'b0);
    chk("R2 no&nc", rlo_o, 1'b1);
    exec(COIL, 8'd64, 8'd0, 1'b0);
    rd_chk("R3 coil high", 8'd64, 1'b1);
    chk("R3 rlo kept", rlo_o, 1'b1);
    hwr(8'd1, 1'b1);
    exec(NO, 8'd0, 8'd0, 1'b1); exec(NC, 8'd1, 8'd0, 1'b0);
    chk("R2 series and", rlo_o, 1'b0);
    exec(COIL, 8'd64, 8'd0, 1'b0);
    rd_chk("R3 coil low", 8'd64, 1'b0);
    exec(NO, 8'd0, 8'd0, 1'b1);
    chk("R2 first loads", rlo_o, 1'b1);
  endtask

  task automatic t_midline;
    hwr(8'd2, 1'b0);
    exec(NO, 8'd0, 8'd0, 1'b1);
    exec(MID, 8'd130, 8'd0, 1'b0);
    chk("R4 rlo passes", rlo_o, 1'b1);
    exec(NO, 8'd2, 8'd0, 1'b0);
    chk("R4 later and", rlo_o, 1'b0);
    rd_chk("R4 stored", 8'd130, 1'b1);
    exec(COIL, 8'd65, 8'd0, 1'b0);
    rd_chk("R4 end coil", 8'd65, 1'b0);
  endtask

  task automatic t_inv_save;
    exec(NO, 8'd0, 8'd0, 1'b1);
    exec(INV, 8'd0, 8'd0, 1'b0);
    chk("R5 inv 1->0", rlo_o, 1'b0);
    exec(SAVE, 8'd0, 8'd0, 1'b0);
    chk("R6 br 0", br_o, 1'b0);
    exec(INV, 8'd0, 8'd0, 1'b0);
    chk("R5 inv 0->1", rlo_o, 1'b1);
    exec(SAVE, 8'd0, 8'd0, 1'b0);
    chk("R6 br 1", br_o, 1'b1);
  endtask

  task automatic t_set_reset;
    exec(NO, 8'd0, 8'd0, 1'b1); exec(SET, 8'd140, 8'd0, 1'b0);
    rd_chk("R7 set", 8'd140, 1'b1);
    exec(NC, 8'd0, 8'd0, 1'b1); exec(RST, 8'd140, 8'd0, 1'b0);
    rd_chk("R7 reset ignored", 8'd140, 1'b1);
    exec(SET, 8'd141, 8'd0, 1'b0);
    rd_chk("R7 set ignored", 8'd141, 1'b0);
    exec(NO, 8'd0, 8'd0, 1'b1); exec(RST, 8'd140, 8'd0, 1'b0);
    rd_chk("R7 reset", 8'd140, 1'b0);
  endtask

  task automatic t_flipflops;
    hwr(8'd150, 1'b1);
    exec(NO, 8'd0, 8'd0, 1'b1); exec(SR, 8'd142, 8'd150, 1'b0);
    rd_chk("R8 both active clears", 8'd142, 1'b0);
    chk("R8 rlo", rlo_o, 1'b0);
    exec(NO, 8'd0, 8'd0, 1'b1); exec(RS, 8'd143, 8'd150, 1'b0);
    rd_chk("R9 both active sets", 8'd143, 1'b1);
    chk("R9 rlo", rlo_o, 1'b1);
    hwr(8'd150, 1'b0);
    exec(NC, 8'd0, 8'd0, 1'b1); exec(SR, 8'd143, 8'd150, 1'b0);
    rd_chk("R8 idle holds", 8'd143, 1'b1);
    chk("R8 rlo holds", rlo_o, 1'b1);
    exec(NO, 8'd0, 8'd0, 1'b1); exec(SR, 8'd142, 8'd150, 1'b0);
    rd_chk("R8 set only", 8'd142, 1'b1);
    hwr(8'd150, 1'b1);
    exec(NC, 8'd0, 8'd0, 1'b1); exec(RS, 8'd143, 8'd150, 1'b0);
    rd_chk("R9 reset only", 8'd143, 1'b0);
    chk("R9 rlo cleared", rlo_o, 1'b0);
  endtask

  task automatic t_rlo_edge;
    exec(NO, 8'd0, 8'd0, 1'b1); exec(PE, 8'd0, 8'd160, 1'b0);
    chk("R10 rise pulse", rlo_o, 1'b1);
    rd_chk("R10 rise mem", 8'd160, 1'b1);
    exec(NO, 8'd0, 8'd0, 1'b1); exec(PE, 8'd0, 8'd160, 1'b0);
    chk("R10 rise once", rlo_o, 1'b0);
    hwr(8'd0, 1'b0);
    exec(NO, 8'd0, 8'd0, 1'b1); exec(PE, 8'd0, 8'd160, 1'b0);
    chk("R10 rise on fall", rlo_o, 1'b0);
    rd_chk("R10 rise mem clr", 8'd160, 1'b0);
    exec(NO, 8'd0, 8'd0, 1'b1); exec(NE, 8'd0, 8'd161, 1'b0);
    chk("R10 fall idle", rlo_o, 1'b0);
    hwr(8'd0, 1'b1);
    exec(NO, 8'd0, 8'd0, 1'b1); exec(NE, 8'd0, 8'd161, 1'b0);
    chk("R10 fall on rise", rlo_o, 1'b0);
    rd_chk("R10 fall mem", 8'd161, 1'b1);
    hwr(8'd0, 1'b0);
    exec(NO, 8'd0, 8'd0, 1'b1); exec(NE, 8'd0, 8'd161, 1'b0);
    chk("R10 fall pulse", rlo_o, 1'b1);
    hwr(8'd0, 1'b1);
  endtask

  task automatic t_addr_edge;
    hwr(8'd3, 1'b1);
    exec(AP, 8'd3, 8'd170, 1'b1);
    chk("R11 pos pulse", rlo_o, 1'b1);
    rd_chk("R11 pos copy", 8'd170, 1'b1);
    exec(AP, 8'd3, 8'd170, 1'b1);
    chk("R11 pos once", rlo_o, 1'b0);
    hwr(8'd3, 1'b0);
    exec(NO, 8'd0, 8'd0, 1'b1); exec(AN, 8'd3, 8'd170, 1'b0);
    chk("R11 neg pulse in series", rlo_o, 1'b1);
    rd_chk("R11 neg copy", 8'd170, 1'b0);
    exec(AN, 8'd3, 8'd170, 1'b1);
    chk("R11 neg once", rlo_o, 1'b0);
  endtask

  task automatic t_host_nop;
    instr_valid_i = 1'b1; opcode_i = NOP; host_we_i = 1'b1;
    host_addr_i = 8'd180; host_wdata_i = 1'b1;
    @(negedge clk_i);
    instr_valid_i = 1'b0; host_we_i = 1'b0;
    rd_chk("R12 host blocked", 8'd180, 1'b0);
    hwr(8'd180, 1'b1);
    rd_chk("R12 host write", 8'd180, 1'b1);
    exec(NO, 8'd0, 8'd0, 1'b1); exec(SAVE, 8'd0, 8'd0, 1'b0);
    exec(NOP, 8'd180, 8'd0, 1'b0);
    chk("R13 nop rlo", rlo_o, 1'b1);
    exec(RSVD, 8'd180, 8'd181, 1'b0);
    chk("R13 rsvd rlo", rlo_o, 1'b1);
    chk("R13 rsvd br", br_o, 1'b1);
    rd_chk("R13 rsvd mem", 8'd180, 1'b1);
    rd_chk("R13 rsvd mem b", 8'd181, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_contacts();
    t_midline();
    t_inv_save();
    t_set_reset();
    t_flipflops();
    t_rlo_edge();
    t_addr_edge();
    t_host_nop();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule